// File: doc/BRIEF.md
# Dual-Clock Deserializer FIFO with One-Shot Start-Read Flag

This block carries 10-bit words from a write clock domain to an independent read clock domain through 15 words of storage. It sits behind a deserializer: the write side runs on the recovered receive clock and the read side on a local system clock. Both data edges are valid/ready streams. A write is taken on a rising write-clock edge when `in_valid` and `in_ready` are both high. A read is taken on a rising read-clock edge when `out_valid` and `out_ready` are both high. The producer must hold its word while `in_ready` is low. `out_data` shows the oldest stored word whenever `out_valid` is high (first-word fall-through). `full` and `empty` are also given as plain status pins.

An active-low start-read flag tells downstream logic when the buffer has first reached about half depth. After each reset it goes low once, at the fill level of five, and it goes high again at six. It then stays high until the buffer is reset again. This flag is computed on the write side from the write pointer and the synchronised read pointer. Reads that arrive early can therefore postpone the low phase or stretch it.

Any of three active-low resets clears the buffer: global, power-on and a dedicated FIFO reset. They are merged into one reset. Each clock domain sees it asserted at once and released on its own clock.

Top module: `xfifo_srd`

## Requirements
- R1: While any reset is low and after release, with no writes, `empty` is 1, `out_valid` is 0, `full` is 0, `in_ready` is 1 and `start_rd_n` is 1.
- R2: Words leave in the order they were accepted, with all 10 bits unchanged. `out_data` holds the oldest word whenever `out_valid` is 1.
- R3: After 15 accepted writes and no reads, `full` is 1 and `in_ready` is 0. After 14 writes, `full` is still 0.
- R4: An `in_valid` while `in_ready` is 0 writes nothing. Exactly the 15 earlier words are read back, and then `empty` is 1.
- R5: An `out_ready` while `out_valid` is 0 removes nothing. A word written later is read back correctly.
- R6: With no reads, `start_rd_n` goes to 0 at the write-clock edge that follows the edge on which the occupancy reaches 5. That is after the 6th consecutive write edge.
- R7: `start_rd_n` returns to 1 at the write-clock edge that follows the edge on which the occupancy reaches 6.
- R8: Once `start_rd_n` has returned to 1, it stays 1 through draining and refilling until the next reset. After that reset it goes low again at the fill level of five.
- R9: Each reset input on its own (`glb_rst_n`, `por_rst_n`, `fifo_rst_n`) empties the buffer and drives the flags to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock (recovered receive clock) |
| rd_clk | input | 1 | Read clock (local clock) |
| glb_rst_n | input | 1 | Global reset, active low |
| por_rst_n | input | 1 | Power-on reset, active low |
| fifo_rst_n | input | 1 | Dedicated buffer reset, active low |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Write accepted this edge if valid; low when full |
| in_data | input | 10 | Write word |
| out_valid | output | 1 | A stored word is presented; low when empty |
| out_ready | input | 1 | Consumer takes the presented word |
| out_data | output | 10 | Oldest stored word |
| full | output | 1 | 15 words held, as seen by the write side |
| empty | output | 1 | No word held, as seen by the read side |
| start_rd_n | output | 1 | One-shot half-full start-read flag, active low |

## Verification
The assertions assume that each reset input is held low for at least two cycles of both clocks. They also assume that the two clocks are free-running and unrelated, so each synchroniser sees one gray-code bit change at a time. The bench meets these assumptions. It holds every reset for several cycles of each clock, drives both clocks with fixed, unrelated periods, and changes inputs only on falling edges. Before it checks the start-read timing exactly, it lets the read pointer settle and issues no reads. This keeps the write-side occupancy equal to the number of writes.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  typedef enum logic [1:0] {
    SRD_ARMED  = 2'd0,
    SRD_ACTIVE = 2'd1,
    SRD_SPENT  = 2'd2
  } srd_state_e;
endpackage

// File: rtl/xf_rst_sync.sv
module xf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage <= 1'b0;
      rst_n <= 1'b0;
    end else begin
      stage <= 1'b1;
      rst_n <= stage;
    end
  end
endmodule

// File: rtl/xf_sync2.sv
module xf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xf_wr_ctrl.sv
module xf_wr_ctrl
  import xfifo_pkg::*;
#(
  parameter int DEPTH   = 15,
  parameter int AW      = 4,
  parameter int PW      = 5,
  parameter int ON_LVL  = 5,
  parameter int OFF_LVL = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] rd_gray_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_gray,
  output logic [PW-1:0] wr_bin,
  output logic [PW-1:0] wr_occ,
  output logic          full,
  output logic          start_rd_n
);
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0] ON_V    = PW'(ON_LVL);
  localparam logic [PW-1:0] OFF_V   = PW'(OFF_LVL);

  logic [PW-1:0] rd_bin_s;
  logic [PW-1:0] bin_nxt;
  srd_state_e    state, state_nxt;

  always_comb begin
    for (int i = 0; i < PW; i++) rd_bin_s[i] = ^(rd_gray_s >> i);
  end

  assign wr_occ  = wr_bin - rd_bin_s;
  assign full    = (wr_occ >= DEPTH_V);
  assign wr_en   = push & ~full;
  assign bin_nxt = wr_bin + PW'(wr_en);
  assign wr_addr = wr_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else begin
      wr_bin  <= bin_nxt;
      wr_gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  always_comb begin
    state_nxt = state;
    case (state)
      SRD_ARMED:  if (wr_occ >= ON_V)  state_nxt = SRD_ACTIVE;
      SRD_ACTIVE: if (wr_occ >= OFF_V) state_nxt = SRD_SPENT;
      default:    state_nxt = SRD_SPENT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SRD_ARMED;
      start_rd_n <= 1'b1;
    end else begin
      state      <= state_nxt;
      start_rd_n <= (state_nxt != SRD_ACTIVE);
    end
  end
endmodule

// File: rtl/xf_rd_ctrl.sv
module xf_rd_ctrl #(
  parameter int AW = 4,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic [PW-1:0] wr_gray_s,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_gray,
  output logic [PW-1:0] rd_bin,
  output logic          empty
);
  logic [PW-1:0] wr_bin_s;
  logic [PW-1:0] bin_nxt;
  logic          rd_en;

  always_comb begin
    for (int i = 0; i < PW; i++) wr_bin_s[i] = ^(wr_gray_s >> i);
  end

  assign empty   = (rd_bin == wr_bin_s);
  assign rd_en   = pop & ~empty;
  assign bin_nxt = rd_bin + PW'(rd_en);
  assign rd_addr = rd_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else begin
      rd_bin  <= bin_nxt;
      rd_gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/xfifo_srd.sv
module xfifo_srd #(
  parameter int W          = 10,
  parameter int DEPTH      = 15,
  parameter int SRD_ON_LVL = 5,
  parameter int SRD_OFF_LVL = 6
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         glb_rst_n,
  input  logic         por_rst_n,
  input  logic         fifo_rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         full,
  output logic         empty,
  output logic         start_rd_n
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW    = AW + 1;
  localparam int SLOTS = 1 << AW;

  logic          arst_n, wr_rst_n, rd_rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, wr_bin, wr_occ, rd_gray, rd_bin;
  logic [PW-1:0] wr_gray_s, rd_gray_s;
  logic [W-1:0]  mem [SLOTS];

  assign arst_n = glb_rst_n & por_rst_n & fifo_rst_n;

  xf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(arst_n), .rst_n(wr_rst_n));
  xf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(arst_n), .rst_n(rd_rst_n));

  xf_sync2 #(.W(PW)) u_rd2wr (.clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_s));
  xf_sync2 #(.W(PW)) u_wr2rd (.clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));

  xf_wr_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .PW(PW), .ON_LVL(SRD_ON_LVL), .OFF_LVL(SRD_OFF_LVL)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .push(in_valid), .rd_gray_s(rd_gray_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray), .wr_bin(wr_bin),
    .wr_occ(wr_occ), .full(full), .start_rd_n(start_rd_n)
  );

  xf_rd_ctrl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .pop(out_ready), .wr_gray_s(wr_gray_s),
    .rd_addr(rd_addr), .rd_gray(rd_gray), .rd_bin(rd_bin), .empty(empty)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= in_data;
  end

  assign out_data  = mem[rd_addr];
  assign out_valid = ~empty;
  assign in_ready  = ~full;
endmodule

// File: rtl/xfifo_srd_chk.sv
module xfifo_srd_chk #(
  parameter int PW     = 5,
  parameter int DEPTH  = 15,
  parameter int ON_LVL = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          in_valid,
  input logic          full,
  input logic          empty,
  input logic          out_ready,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] wr_occ,
  input logic          start_rd_n
);
  logic srd_prev, spent;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      srd_prev <= 1'b1;
      spent    <= 1'b0;
    end else begin
      srd_prev <= start_rd_n;
      if (!srd_prev && start_rd_n) spent <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && full) |=> $stable(wr_bin)); // R4
  AST_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    32'(wr_occ) <= DEPTH); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (out_ready && empty) |=> $stable(rd_bin)); // R5
  AST_SRD_ENTRY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(start_rd_n) |-> 32'($past(wr_occ)) >= ON_LVL); // R6
  AST_SRD_ONE_SHOT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    spent |-> start_rd_n); // R8
endmodule

bind xfifo_srd xfifo_srd_chk #(.PW(PW), .DEPTH(DEPTH), .ON_LVL(SRD_ON_LVL)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .in_valid(in_valid), .full(full), .empty(empty), .out_ready(out_ready),
  .wr_bin(wr_bin), .rd_bin(rd_bin), .wr_occ(wr_occ), .start_rd_n(start_rd_n)
);

// File: tb/tb_xfifo_srd.sv
module tb_xfifo_srd;
  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic glb_rst_n = 1'b0, por_rst_n = 1'b0, fifo_rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [9:0] in_data = '0;
  logic in_ready, out_valid, full, empty, start_rd_n;
  logic [9:0] out_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  xfifo_srd dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .glb_rst_n(glb_rst_n), .por_rst_n(por_rst_n),
    .fifo_rst_n(fifo_rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .full(full), .empty(empty), .start_rd_n(start_rd_n)
  );

  // entry: [11:2] data, [1] start_rd_n expected after this write, [0] full expected
  localparam logic [11:0] VEC [15] = '{
    {10'h001, 1'b1, 1'b0}, {10'h2AA, 1'b1, 1'b0}, {10'h155, 1'b1, 1'b0},
    {10'h3FF, 1'b1, 1'b0}, {10'h000, 1'b1, 1'b0}, {10'h0F0, 1'b0, 1'b0},
    {10'h30F, 1'b1, 1'b0}, {10'h1E3, 1'b1, 1'b0}, {10'h2C7, 1'b1, 1'b0},
    {10'h38E, 1'b1, 1'b0}, {10'h071, 1'b1, 1'b0}, {10'h123, 1'b1, 1'b0},
    {10'h246, 1'b1, 1'b0}, {10'h08C, 1'b1, 1'b0}, {10'h3A5, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_state(input string req);
    chk(empty == 1'b1, {req, " empty"}, int'(empty), 1);
    chk(out_valid == 1'b0, {req, " out_valid"}, int'(out_valid), 0);
    chk(full == 1'b0, {req, " full"}, int'(full), 0);
    chk(in_ready == 1'b1, {req, " in_ready"}, int'(in_ready), 1);
    chk(start_rd_n == 1'b1, {req, " start_rd_n"}, int'(start_rd_n), 1);
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic write_word(input logic [9:0] d);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge wr_clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state while held and after release
    repeat (4) @(negedge wr_clk);
    idle_state("R1 in reset");
    glb_rst_n = 1'b1; por_rst_n = 1'b1; fifo_rst_n = 1'b1;
    settle();
    idle_state("R1 after release");

    // Table walk: R3, R6, R7 (no reads, occupancy equals writes)
    for (int i = 0; i < 15; i++) begin
      in_valid = 1'b1;
      in_data  = VEC[i][11:2];
      @(negedge wr_clk);
      chk(start_rd_n == VEC[i][1], $sformatf("R6/R7 start_rd_n after write %0d", i + 1),
          int'(start_rd_n), int'(VEC[i][1]));
      chk(full == VEC[i][0], $sformatf("R3 full after write %0d", i + 1),
          int'(full), int'(VEC[i][0]));
    end
    chk(in_ready == 1'b0, "R3 in_ready when full", int'(in_ready), 0);

    // R4: offered word while full is dropped
    in_data = 10'h3C3;
    repeat (3) @(negedge wr_clk);
    chk(full == 1'b1, "R4 full held", int'(full), 1);
    in_valid = 1'b0;
    repeat (6) @(negedge rd_clk);

    // R2/R4: read back exactly the 15 stored words in order
    for (int i = 0; i < 15; i++) begin
      chk(out_valid == 1'b1, $sformatf("R2 out_valid word %0d", i), int'(out_valid), 1);
      chk(out_data == VEC[i][11:2], $sformatf("R2 out_data word %0d", i),
          int'(out_data), int'(VEC[i][11:2]));
      out_ready = 1'b1;
      @(negedge rd_clk);
    end
    chk(empty == 1'b1, "R4 empty after 15 reads", int'(empty), 1);

    // R5: reading while empty removes nothing
    repeat (3) @(negedge rd_clk);
    chk(out_valid == 1'b0, "R5 out_valid while empty", int'(out_valid), 0);
    out_ready = 1'b0;
    settle();
    write_word(10'h2B4);
    chk(start_rd_n == 1'b1, "R8 start_rd_n after drain", int'(start_rd_n), 1);
    repeat (6) @(negedge rd_clk);
    chk(out_valid == 1'b1, "R5 out_valid after late write", int'(out_valid), 1);
    chk(out_data == 10'h2B4, "R5 out_data after late write", int'(out_data), 32'h2B4);
    out_ready = 1'b1;
    @(negedge rd_clk);
    out_ready = 1'b0;
    chk(empty == 1'b1, "R5 empty after single read", int'(empty), 1);
    settle();

    // R8: refill past five, flag stays high
    for (int i = 0; i < 8; i++) begin
      write_word(VEC[i][11:2]);
      chk(start_rd_n == 1'b1, $sformatf("R8 spent flag refill %0d", i + 1), int'(start_rd_n), 1);
    end

    // R9: dedicated buffer reset, then the flag rearms (R8)
    @(negedge wr_clk);
    fifo_rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    idle_state("R9 fifo_rst_n held");
    fifo_rst_n = 1'b1;
    settle();
    idle_state("R9 after fifo_rst_n");
    for (int i = 0; i < 7; i++) begin
      in_valid = 1'b1;
      in_data  = VEC[i][11:2];
      @(negedge wr_clk);
      chk(start_rd_n == VEC[i][1], $sformatf("R8 rearmed flag after write %0d", i + 1),
          int'(start_rd_n), int'(VEC[i][1]));
    end
    in_valid = 1'b0;
    repeat (6) @(negedge rd_clk);
    chk(out_data == VEC[0][11:2], "R2 first word after rearm", int'(out_data), int'(VEC[0][11:2]));

    // R9: global reset clears held content
    glb_rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    glb_rst_n = 1'b1;
    settle();
    idle_state("R9 after glb_rst_n");

    // R9: power-on reset clears held content
    write_word(10'h155);
    write_word(10'h0AA);
    repeat (6) @(negedge rd_clk);
    chk(out_valid == 1'b1, "R9 content before por", int'(out_valid), 1);
    por_rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    por_rst_n = 1'b1;
    settle();
    idle_state("R9 after por_rst_n");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule